// File: doc/BRIEF.md
# Register-Indirect Jump Target and Link Unit

This unit works out where a register-indirect jump goes and what return address it leaves behind. It takes a 12-bit signed immediate, sign-extends it, and adds it to a base register value as a byte offset. The offset is not doubled the way conditional-branch offsets are. The sum, with its lowest bit forced to zero, becomes the jump target. The return address is the current PC plus the length of the jump instruction: 2 bytes for a compressed encoding, 4 for a full-width one.

In normal mode, an odd base combined with an odd immediate carries out of bit 0, so the target moves two bytes forward. A hardened mode clears bit 0 of both operands before the add, so that carry cannot happen. In either mode a diagnostic flag reports when both low bits are set. An alignment check traps any target off a 4-byte boundary while 16-bit instructions are disabled. A flagged target is still presented on the next-PC output, so that a trap can report it.

Results are captured in an output register when the capture enable is high, and appear one cycle later. Register access, decode, fetch and trap handling belong to the surrounding core. The unit has no back-pressure: every cycle with the capture enable high is accepted. The register is built only when the `REG_OUT` parameter is set, which is the default.

Top module: `jrl_unit`

## Requirements
- R1: The target equals the base plus the sign-extended immediate, taken as a byte offset and wrapping modulo 2^XLEN, with bit 0 of the sum then forced to 0 (normal mode, `harden`=0).
- R2: Bit 0 of `next_pc` is always 0 after a capture.
- R3: In normal mode, an odd base with an odd immediate gives a target exactly 2 greater than the same base with bit 0 cleared.
- R4: With `harden`=1, bit 0 of the base and bit 0 of the sign-extended immediate are both cleared before the add, so bit 1 of the target is the XOR of bit 1 of the two operands.
- R5: `odd_carry` is 1 exactly when bit 0 of `base_val` and bit 0 of `imm12` are both 1, in either mode.
- R6: With `rvc_on`=1, every target is legal: `misalign`=0 and `tgt_ok`=1.
- R7: With `rvc_on`=0, a target whose bit 1 is 1 sets `misalign`=1 and `tgt_ok`=0. `next_pc` still carries that target.
- R8: `link_pc` equals `cur_pc` + 2 when `is_short`=1 and `cur_pc` + 4 when `is_short`=0, wrapping modulo 2^XLEN.
- R9: Outputs take the values for the inputs present at a rising edge where `cap_en`=1 and `rst`=0. With `cap_en`=0, all outputs hold.
- R10: A rising edge with `rst`=1 clears `tgt_ok`, `misalign` and `odd_carry` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high; clears the flags |
| cap_en | input | 1 | Capture enable for the output register |
| cur_pc | input | XLEN | Address of the jump instruction |
| base_val | input | XLEN | Base register value |
| imm12 | input | 12 | Signed byte offset |
| is_short | input | 1 | 1 = 16-bit jump encoding, 0 = 32-bit |
| rvc_on | input | 1 | 1 = 16-bit instructions enabled |
| harden | input | 1 | 1 = block the carry out of bit 0 |
| next_pc | output | XLEN | Jump target |
| link_pc | output | XLEN | Return address |
| tgt_ok | output | 1 | Target is usable (no alignment trap) |
| misalign | output | 1 | Misaligned-target exception flag |
| odd_carry | output | 1 | Both operand low bits were set |

## Verification
The assertions assume the inputs are stable around the rising edge. They also assume the instance uses the registered configuration, because each property relates the inputs present at a capture edge to the outputs in the cycle after it. The bench changes inputs only on falling edges and samples outputs 2 ns after each rising edge, which keeps it inside that assumption. Reset is asserted only at whole-cycle boundaries, so the properties that carry `disable iff` never observe a partial reset.

// File: rtl/jrl_pkg.sv
package jrl_pkg;

  // Width of the immediate field carried by the jump encoding.
  localparam int unsigned IMM_W = 12;

  // Return-address step for each instruction length, in bytes.
  localparam int unsigned STEP_SHORT = 2;
  localparam int unsigned STEP_FULL  = 4;

  // Instruction length selector.
  typedef enum logic {
    LEN_FULL  = 1'b0,
    LEN_SHORT = 1'b1
  } ilen_e;

  // Flags produced alongside the addresses.
  typedef struct packed {
    logic ok;
    logic mis;
    logic odd;
  } jrl_flags_t;

  localparam jrl_flags_t FLAGS_CLEAR = '{ok: 1'b0, mis: 1'b0, odd: 1'b0};

endpackage

// File: rtl/jrl_target_calc.sv
module jrl_target_calc
  import jrl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic             harden,
  output logic [XLEN-1:0]  target,
  output logic             odd_pair
);

  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic [XLEN-1:0] sum;

  // Sign extension of the byte offset (not scaled).
  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_x = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_x = imm[XLEN-1:0];
    end
  endgenerate

  // Hardened mode strips the low bit of each operand before the add.
  always_comb begin
    op_a = base;
    op_b = imm_x;
    if (harden) begin
      op_a[0] = 1'b0;
      op_b[0] = 1'b0;
    end
  end

  assign sum      = op_a + op_b;
  assign target   = {sum[XLEN-1:1], 1'b0};
  assign odd_pair = base[0] & imm[0];

endmodule

// File: rtl/jrl_align_chk.sv
module jrl_align_chk
  import jrl_pkg::*;
(
  input  logic tgt_bit1,
  input  logic rvc_on,
  output logic ok,
  output logic mis
);

  // Bit 0 is always clear, so only bit 1 decides 4-byte alignment.
  always_comb begin
    mis = 1'b0;
    if (!rvc_on) begin
      mis = tgt_bit1;
    end
    ok = ~mis;
  end

endmodule

// File: rtl/jrl_link_calc.sv
module jrl_link_calc
  import jrl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  ilen_e           len,
  output logic [XLEN-1:0] link
);

  localparam logic [XLEN-1:0] INC_S = XLEN'(STEP_SHORT);
  localparam logic [XLEN-1:0] INC_F = XLEN'(STEP_FULL);

  logic [XLEN-1:0] inc;

  always_comb begin
    unique case (len)
      LEN_SHORT: inc = INC_S;
      default:   inc = INC_F;
    endcase
  end

  assign link = pc + inc;

endmodule

// File: rtl/jrl_out_stage.sv
module jrl_out_stage
  import jrl_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic [XLEN-1:0] d_tgt,
  input  logic [XLEN-1:0] d_link,
  input  jrl_flags_t      d_flags,
  output logic [XLEN-1:0] q_tgt,
  output logic [XLEN-1:0] q_link,
  output jrl_flags_t      q_flags
);

  generate
    if (REG_OUT) begin : g_reg
      logic [XLEN-1:0] tgt_r;
      logic [XLEN-1:0] link_r;
      jrl_flags_t      flags_r;

      // Flags take the synchronous reset; data registers do not need it.
      always_ff @(posedge clk) begin
        if (rst) begin
          flags_r <= FLAGS_CLEAR;
        end else if (cap_en) begin
          flags_r <= d_flags;
        end
      end

      always_ff @(posedge clk) begin
        if (cap_en && !rst) begin
          tgt_r  <= d_tgt;
          link_r <= d_link;
        end
      end

      assign q_tgt   = tgt_r;
      assign q_link  = link_r;
      assign q_flags = flags_r;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst ^ cap_en;
      assign q_tgt      = d_tgt;
      assign q_link     = d_link;
      assign q_flags    = d_flags;
    end
  endgenerate

endmodule

// File: rtl/jrl_unit.sv
module jrl_unit
  import jrl_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  base_val,
  input  logic [IMM_W-1:0] imm12,
  input  logic             is_short,
  input  logic             rvc_on,
  input  logic             harden,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  link_pc,
  output logic             tgt_ok,
  output logic             misalign,
  output logic             odd_carry
);

  logic [XLEN-1:0] tgt_c;
  logic [XLEN-1:0] link_c;
  logic            odd_c;
  logic            ok_c;
  logic            mis_c;
  jrl_flags_t      flags_c;
  jrl_flags_t      flags_q;
  ilen_e           len_sel;

  assign len_sel = is_short ? LEN_SHORT : LEN_FULL;

  jrl_target_calc #(.XLEN(XLEN)) u_tgt (
    .base     (base_val),
    .imm      (imm12),
    .harden   (harden),
    .target   (tgt_c),
    .odd_pair (odd_c)
  );

  jrl_align_chk u_align (
    .tgt_bit1 (tgt_c[1]),
    .rvc_on   (rvc_on),
    .ok       (ok_c),
    .mis      (mis_c)
  );

  jrl_link_calc #(.XLEN(XLEN)) u_link (
    .pc   (cur_pc),
    .len  (len_sel),
    .link (link_c)
  );

  assign flags_c = '{ok: ok_c, mis: mis_c, odd: odd_c};

  jrl_out_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .d_tgt   (tgt_c),
    .d_link  (link_c),
    .d_flags (flags_c),
    .q_tgt   (next_pc),
    .q_link  (link_pc),
    .q_flags (flags_q)
  );

  assign tgt_ok    = flags_q.ok;
  assign misalign  = flags_q.mis;
  assign odd_carry = flags_q.odd;

endmodule

// File: rtl/jrl_unit_chk.sv
module jrl_unit_chk #(
  parameter int unsigned XLEN    = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            cap_en,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] base_val,
  input logic [11:0]     imm12,
  input logic            is_short,
  input logic            rvc_on,
  input logic            harden,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] link_pc,
  input logic            tgt_ok,
  input logic            misalign,
  input logic            odd_carry
);

  localparam logic [XLEN-1:0] TWO  = XLEN'(2);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  generate
    if (REG_OUT) begin : g_props
      // R10: reset clears every flag
      p_flags_clear_r10: assert property (@(posedge clk)
        rst |=> (!tgt_ok && !misalign && !odd_carry));

      // R2: captured target is half-word aligned
      p_even_target_r2: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> !next_pc[0]);

      // R5: odd-pair diagnostic follows the operand low bits
      p_odd_flag_r5: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (odd_carry == ($past(base_val[0]) && $past(imm12[0]))));

      // R4: hardened mode lets no carry reach bit 1
      p_no_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_en && harden) |=> (next_pc[1] == ($past(base_val[1]) ^ $past(imm12[1]))));

      // R6: compressed enabled never traps
      p_rvc_legal_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_en && rvc_on) |=> (tgt_ok && !misalign));

      // R7: without compressed, trap tracks target bit 1
      p_trap_bit1_r7: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !rvc_on) |=> ((misalign == next_pc[1]) && (tgt_ok != misalign)));

      // R8: link is PC plus the instruction length
      p_link_step_r8: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (link_pc == ($past(cur_pc) + ($past(is_short) ? TWO : FOUR))));

      // R9: outputs hold when capture is off
      p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> ($stable(next_pc) && $stable(link_pc) && $stable(tgt_ok)
                     && $stable(misalign) && $stable(odd_carry)));
    end
  endgenerate

endmodule

bind jrl_unit jrl_unit_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cap_en    (cap_en),
  .cur_pc    (cur_pc),
  .base_val  (base_val),
  .imm12     (imm12),
  .is_short  (is_short),
  .rvc_on    (rvc_on),
  .harden    (harden),
  .next_pc   (next_pc),
  .link_pc   (link_pc),
  .tgt_ok    (tgt_ok),
  .misalign  (misalign),
  .odd_carry (odd_carry)
);

// File: tb/jrl_unit_tb.sv
`timescale 1ns/1ps
module jrl_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        cap_en;
  logic [31:0] cur_pc;
  logic [31:0] base_val;
  logic [11:0] imm12;
  logic        is_short;
  logic        rvc_on;
  logic        harden;
  logic [31:0] next_pc;
  logic [31:0] link_pc;
  logic        tgt_ok;
  logic        misalign;
  logic        odd_carry;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference state
  logic [31:0] m_tgt, m_link;
  logic        m_ok, m_mis, m_odd;
  bit          m_data_known = 1'b0;

  always #5 clk = ~clk;

  jrl_unit u_dut (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cur_pc(cur_pc),
    .base_val(base_val), .imm12(imm12), .is_short(is_short),
    .rvc_on(rvc_on), .harden(harden), .next_pc(next_pc),
    .link_pc(link_pc), .tgt_ok(tgt_ok), .misalign(misalign),
    .odd_carry(odd_carry)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of one clock edge.
  task automatic model_edge();
    int          off;
    logic [31:0] t;
    if (rst) begin
      m_ok = 0; m_mis = 0; m_odd = 0;
    end else if (cap_en) begin
      off = $signed(imm12);
      if (harden) t = (base_val & ~32'd1) + (off & ~32'd1);
      else        t = (base_val + off) & ~32'd1;
      m_tgt  = t;
      m_link = cur_pc + (is_short ? 32'd2 : 32'd4);
      m_mis  = !rvc_on && ((t % 4) != 0);
      m_ok   = !m_mis;
      m_odd  = (base_val % 2 == 1) && (imm12 % 2 == 1);
      m_data_known = 1'b1;
    end
  endtask

  task automatic compare(input string ctx);
    if (m_data_known) begin
      chk({ctx, " R1 next_pc"}, next_pc, m_tgt);
      chk({ctx, " R8 link_pc"}, link_pc, m_link);
    end
    chk({ctx, " R6/R7 tgt_ok"}, {31'd0, tgt_ok}, {31'd0, m_ok});
    chk({ctx, " R7 misalign"}, {31'd0, misalign}, {31'd0, m_mis});
    chk({ctx, " R5 odd_carry"}, {31'd0, odd_carry}, {31'd0, m_odd});
  endtask

  task automatic step(input string ctx, input bit r, input bit en,
                      input logic [31:0] pc, input logic [31:0] b,
                      input logic [11:0] im, input bit sh,
                      input bit rv, input bit hd);
    @(negedge clk);
    rst = r; cap_en = en; cur_pc = pc; base_val = b; imm12 = im;
    is_short = sh; rvc_on = rv; harden = hd;
    @(posedge clk);
    model_edge();
    #2;
    compare(ctx);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t_even;
    rst = 1; cap_en = 0; cur_pc = 0; base_val = 0; imm12 = 0;
    is_short = 0; rvc_on = 1; harden = 0;

    // R10: reset state
    step("R10 reset", 1, 1, 32'h100, 32'h11, 12'h3, 0, 1, 0);
    step("R10 reset", 1, 0, 0, 0, 0, 0, 1, 0);

    // R1: plain add, positive and negative offsets, wrap
    step("R1 even", 0, 1, 32'h1000, 32'h2000, 12'h010, 0, 1, 0);
    step("R1 neg",  0, 1, 32'h1000, 32'h2000, 12'hFF0, 0, 1, 0);
    step("R1 wrap", 0, 1, 32'h1000, 32'hFFFF_FFFE, 12'h004, 0, 1, 0);
    chk("R1 wrap explicit", next_pc, 32'h0000_0002);
    // R1/R2: odd base, even imm, low bit dropped
    step("R2 oddbase", 0, 1, 32'h1000, 32'h2001, 12'h008, 0, 1, 0);
    chk("R2 low bit", next_pc, 32'h2008);

    // R3: double-odd carry in normal mode
    step("R3 evenref", 0, 1, 32'h1000, 32'h3000, 12'h005, 0, 1, 0);
    t_even = next_pc;
    step("R3 odd", 0, 1, 32'h1000, 32'h3001, 12'h005, 0, 1, 0);
    chk("R3 plus two", next_pc, t_even + 32'd2);
    chk("R5 flag set", {31'd0, odd_carry}, 32'd1);

    // R4: hardened mode blocks the carry but still flags
    step("R4 hard", 0, 1, 32'h1000, 32'h3001, 12'h005, 0, 1, 1);
    chk("R4 no carry", next_pc, t_even);
    chk("R4/R5 flag", {31'd0, odd_carry}, 32'd1);

    // R7: compressed disabled, misaligned and aligned targets
    step("R7 mis", 0, 1, 32'h1000, 32'h4000, 12'h002, 0, 0, 0);
    chk("R7 trap tgt", next_pc, 32'h4002);
    chk("R7 trap flag", {31'd0, misalign}, 32'd1);
    step("R7 aligned", 0, 1, 32'h1000, 32'h4000, 12'h004, 0, 0, 0);
    // R6: same misaligned target accepted with compressed enabled
    step("R6 legal", 0, 1, 32'h1000, 32'h4000, 12'h002, 0, 1, 0);
    chk("R6 ok", {31'd0, tgt_ok}, 32'd1);

    // R8: link steps, including wrap
    step("R8 short", 0, 1, 32'h0000_1234, 0, 0, 1, 1, 0);
    chk("R8 short", link_pc, 32'h0000_1236);
    step("R8 full", 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 1, 0);
    chk("R8 wrap", link_pc, 32'h0000_0002);

    // R9: hold with capture off
    step("R9 load", 0, 1, 32'h500, 32'h7001, 12'h001, 0, 0, 0);
    step("R9 hold", 0, 0, 32'h900, 32'h0000, 12'h002, 1, 1, 1);
    chk("R9 held", next_pc, 32'h7002);

    // R10: mid-run reset clears flags
    step("R10 mid", 1, 1, 32'h600, 32'h7001, 12'h001, 0, 0, 0);
    chk("R10 flags", {29'd0, tgt_ok, misalign, odd_carry}, 32'd0);

    // Random mix against the model
    for (int i = 0; i < 600; i++) begin
      step("rand", ($urandom % 40) == 0, ($urandom % 5) != 0, $urandom,
           $urandom, 12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule